// File: doc/BRIEF.md
# Byte ALU with Condition and System Flags

This block is the arithmetic core of a small 8-bit controller. It combines a combinational arithmetic and logic unit with the status register that the unit's flags are written into. The ALU supports these operations:

- binary add and subtract, each with or without the stored carry;
- decimal adjust after a packed-BCD addition;
- bitwise AND, OR, XOR and complement;
- rotates, with or without the carry;
- increment and decrement.

Each operation updates only its own subset of the four condition flags: carry, half carry, zero and overflow. The same register also holds two system flags, power-down and watchdog time-out. Software cannot write these two flags. They follow only the power-up, HALT, clear-watchdog and watchdog-overflow event strobes.

Each cycle the surrounding core presents two operands and an opcode. It reads the result and a zero indication combinationally; the zero indication is what it uses for skip decisions. When the flag-update enable is high, the flags chosen by the opcode are captured at the next rising clock edge. A software write to the status register takes precedence over a flag update in the same cycle.

Top module: `alu8_status`

## Requirements
- R1: ADD (code 0) gives a+b. ADC (code 1) gives a+b+C. C is the carry out of bit 7 and AC is the carry out of bit 3. All four condition flags are updated when flag_en is high.
- R2: SUB (code 2) gives a-b, computed as a+~b+1. SBC (code 3) gives a+~b+C. C is set when no borrow occurs, and AC is set when there is no borrow out of the low nibble.
- R3: For codes 0 to 3, OV is the carry into bit 7 XOR the carry out of bit 7.
- R4: res_zero is high exactly when result is 0. Every operation except the rotates (codes 9 to 12) and the reserved code 15 copies it into Z.
- R5: DAA (code 4) works on a. It adds 06h if a[3:0]>9 or AC=1. It then adds 60h if the upper nibble of that sum is >9 or C=1. C becomes 1 if either addition carries out of bit 7, and otherwise keeps its value. Z is updated, and AC and OV are unchanged.
- R6: AND (5), OR (6), XOR (7), complement of a (8), increment a (13) and decrement a (14) change only Z.
- R7: RL (9) and RR (10) rotate a by one bit and change no flag. RLC (11) and RRC (12) rotate a through C: the bit shifted out goes to C, and the old C enters at the other end.
- R8: While flag_en and st_wr are both low, the four condition flags hold their value, whatever the opcode or operands.
- R9: When st_wr is high, status[3:0] takes st_wdata[3:0] at the next edge, even if flag_en is also high. Bits 5:4 are not affected by the write, and bits 7:6 always read 0.
- R10: PDF is status[4]. ev_pwrup clears it. Otherwise ev_halt sets it, and otherwise ev_clrwdt clears it.
- R11: TO is status[5]. ev_pwrup clears it. Otherwise ev_wdtovf sets it, and otherwise ev_halt or ev_clrwdt clears it.
- R12: After reset the status byte is 00h.
- R13: Opcode 15 is reserved. It gives result 0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First operand, and the only operand of the unary operations |
| op_b | input | 8 | Second operand |
| opcode | input | 4 | Operation select, 0 to 15 |
| flag_en | input | 1 | Capture this operation's flags at the next edge |
| st_wr | input | 1 | Software write of the condition flags |
| st_wdata | input | 8 | Write data; only bits 3:0 are used |
| ev_pwrup | input | 1 | Power-up event strobe |
| ev_halt | input | 1 | HALT event strobe |
| ev_clrwdt | input | 1 | Clear-watchdog event strobe |
| ev_wdtovf | input | 1 | Watchdog overflow event strobe |
| result | output | 8 | Combinational ALU result |
| res_zero | output | 1 | Result equals zero |
| status | output | 8 | {2'b00, TO, PDF, OV, Z, AC, C} |

## Verification
A corrupted flag register shows up in two ways. It is visible on status one edge after the faulty update. It also changes result at once, in the same cycle as any following ADC, SBC, DAA or carry rotate that consumes the flag. The bench therefore runs chains of operations that depend on carry. It checks the result in the same cycle, so that a wrong stored carry or half carry is caught before the next edge. The system flags are checked the cycle after each event combination, including simultaneous strobes, where a wrong priority would leave a different TO or PDF.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_DAA = 4'd4,
      OP_AND = 4'd5,
      OP_OR  = 4'd6,
      OP_XOR = 4'd7,
      OP_CPL = 4'd8,
      OP_RL  = 4'd9,
      OP_RR  = 4'd10,
      OP_RLC = 4'd11,
      OP_RRC = 4'd12,
      OP_INC = 4'd13,
      OP_DEC = 4'd14,
      OP_RSV = 4'd15
   } alu_op_e;

   // status byte layout, decoded by the core around this block
   localparam int ST_C   = 0;
   localparam int ST_AC  = 1;
   localparam int ST_Z   = 2;
   localparam int ST_OV  = 3;
   localparam int ST_PDF = 4;
   localparam int ST_TO  = 5;

   localparam int NIB_W  = 4;
   localparam int COND_W = 4;

   // condition flags in their status-bit order
   typedef struct packed {
      logic ov;
      logic z;
      logic ac;
      logic c;
   } cond_flags_t;

endpackage

// File: rtl/alu_addsub_daa.sv
module alu_addsub_daa
   import alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit HAS_DAA = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   input  logic              c_in,
   input  logic              ac_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out,
   output logic              ac_out,
   output logic              ov_out
);

   localparam int LOW_W = DATA_W - 1;

   logic              is_sub;
   logic              cin;
   logic [DATA_W-1:0] b_eff;
   logic [NIB_W:0]    nib_sum;
   logic [LOW_W:0]    low_sum;
   logic [DATA_W:0]   full_sum;
   logic [DATA_W-1:0] daa_res;
   logic              daa_c;

   always_comb begin
      is_sub = (op == OP_SUB) || (op == OP_SBC);
      b_eff  = is_sub ? ~b : b;
      case (op)
         OP_ADD:  cin = 1'b0;
         OP_SUB:  cin = 1'b1;
         default: cin = c_in;
      endcase
   end

   assign nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
   assign low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
   assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

   generate
      if (HAS_DAA) begin : g_daa
         if (DATA_W != 8) begin : g_daa_width_bad
            $error("decimal adjust needs an 8-bit datapath");
         end
         logic       adj_lo;
         logic       adj_hi;
         logic [8:0] step1;
         logic [8:0] step2;
         always_comb begin
            adj_lo  = (a[3:0] > 4'd9) || ac_in;
            step1   = {1'b0, a} + (adj_lo ? 9'h006 : 9'h000);
            adj_hi  = (step1[7:4] > 4'd9) || c_in;
            step2   = {1'b0, step1[7:0]} + (adj_hi ? 9'h060 : 9'h000);
            daa_res = step2[7:0];
            daa_c   = c_in | step1[8] | step2[8];
         end
      end else begin : g_no_daa
         assign daa_res = a;
         assign daa_c   = c_in;
      end
   endgenerate

   assign res    = (op == OP_DAA) ? daa_res : full_sum[DATA_W-1:0];
   assign c_out  = (op == OP_DAA) ? daa_c   : full_sum[DATA_W];
   assign ac_out = nib_sum[NIB_W];
   assign ov_out = low_sum[LOW_W] ^ full_sum[DATA_W];

endmodule

// File: rtl/alu_logic_rot.sv
module alu_logic_rot
   import alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_op_e           op,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   always_comb begin
      c_out = c_in;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_CPL:  res = ~a;
         OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
         OP_RR:   res = {a[0], a[DATA_W-1:1]};
         OP_RLC: begin
            res   = {a[DATA_W-2:0], c_in};
            c_out = a[DATA_W-1];
         end
         OP_RRC: begin
            res   = {c_in, a[DATA_W-1:1]};
            c_out = a[0];
         end
         OP_INC:  res = a + ONE;
         OP_DEC:  res = a - ONE;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [COND_W-1:0] upd_mask,
   input  logic [COND_W-1:0] upd_val,
   input  logic              wr_en,
   input  logic [COND_W-1:0] wr_data,
   input  logic              ev_pwrup,
   input  logic              ev_halt,
   input  logic              ev_clrwdt,
   input  logic              ev_wdtovf,
   output logic [7:0]        status
);

   logic [COND_W-1:0] cond_q;
   logic              pdf_q;
   logic              to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= '0;
      end else if (wr_en) begin
         cond_q <= wr_data;
      end else if (upd_en) begin
         cond_q <= (cond_q & ~upd_mask) | (upd_val & upd_mask);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdf_q <= 1'b0;
         to_q  <= 1'b0;
      end else if (ev_pwrup) begin
         pdf_q <= 1'b0;
         to_q  <= 1'b0;
      end else begin
         if (ev_halt)        pdf_q <= 1'b1;
         else if (ev_clrwdt) pdf_q <= 1'b0;
         if (ev_wdtovf)                 to_q <= 1'b1;
         else if (ev_halt || ev_clrwdt) to_q <= 1'b0;
      end
   end

   assign status = {2'b00, to_q, pdf_q, cond_q};

   a_r8_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !wr_en) |=> $stable(status[COND_W-1:0]));

   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> status[COND_W-1:0] == $past(wr_data));

   a_r9_write_spares_sys: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ev_pwrup && !ev_halt && !ev_clrwdt && !ev_wdtovf) |=> $stable(status[ST_TO:ST_PDF]));

   a_r10_pwrup_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pwrup |=> (status[ST_PDF] == 1'b0) && (status[ST_TO] == 1'b0));

   a_r10_halt_sets_pdf: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_halt && !ev_pwrup) |=> status[ST_PDF]);

   a_r11_wdt_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wdtovf && !ev_pwrup) |=> status[ST_TO]);

endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit HAS_DAA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        opcode,
   input  logic              flag_en,
   input  logic              st_wr,
   input  logic [7:0]        st_wdata,
   input  logic              ev_pwrup,
   input  logic              ev_halt,
   input  logic              ev_clrwdt,
   input  logic              ev_wdtovf,
   output logic [DATA_W-1:0] result,
   output logic              res_zero,
   output logic [7:0]        status
);

   generate
      if ((DATA_W < 8) || ((DATA_W % NIB_W) != 0)) begin : g_width_bad
         $error("DATA_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] ar_res;
   logic              ar_c;
   logic              ar_ac;
   logic              ar_ov;
   logic [DATA_W-1:0] lg_res;
   logic              lg_c;
   logic [COND_W-1:0] upd_mask;
   cond_flags_t       upd_val;
   logic              wdata_unused;

   assign op           = alu_op_e'(opcode);
   assign wdata_unused = ^st_wdata[7:COND_W];

   alu_addsub_daa #(.DATA_W(DATA_W), .HAS_DAA(HAS_DAA)) u_arith (
      .a      (op_a),
      .b      (op_b),
      .op     (op),
      .c_in   (status[ST_C]),
      .ac_in  (status[ST_AC]),
      .res    (ar_res),
      .c_out  (ar_c),
      .ac_out (ar_ac),
      .ov_out (ar_ov)
   );

   alu_logic_rot #(.DATA_W(DATA_W)) u_logic (
      .a     (op_a),
      .b     (op_b),
      .op    (op),
      .c_in  (status[ST_C]),
      .res   (lg_res),
      .c_out (lg_c)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DAA: result = ar_res;
         default:                                result = lg_res;
      endcase
   end

   assign res_zero = (result == '0);

   always_comb begin
      upd_val    = cond_flags_t'(status[COND_W-1:0]);
      upd_val.z  = res_zero;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            upd_mask   = 4'b1111;
            upd_val.c  = ar_c;
            upd_val.ac = ar_ac;
            upd_val.ov = ar_ov;
         end
         OP_DAA: begin
            upd_mask  = 4'b0101;
            upd_val.c = ar_c;
         end
         OP_RLC, OP_RRC: begin
            upd_mask  = 4'b0001;
            upd_val.c = lg_c;
         end
         OP_RL, OP_RR, OP_RSV: upd_mask = 4'b0000;
         default:              upd_mask = 4'b0100;
      endcase
   end

   alu_status_reg u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (flag_en),
      .upd_mask  (upd_mask),
      .upd_val   (upd_val),
      .wr_en     (st_wr),
      .wr_data   (st_wdata[COND_W-1:0]),
      .ev_pwrup  (ev_pwrup),
      .ev_halt   (ev_halt),
      .ev_clrwdt (ev_clrwdt),
      .ev_wdtovf (ev_wdtovf),
      .status    (status)
   );

   logic z_tracked;
   assign z_tracked = !(opcode inside {4'd9, 4'd10, 4'd11, 4'd12, 4'd15});

   a_r4_z_from_result: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !st_wr && z_tracked) |=> status[ST_Z] == $past(res_zero));

   a_r7_plain_rot_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !st_wr && (opcode == 4'd9 || opcode == 4'd10)) |=> $stable(status[COND_W-1:0]));

   a_r13_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_wr && opcode == 4'd15) |=> $stable(status[COND_W-1:0]));

   a_r6_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_wr && opcode inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd13, 4'd14})
      |=> $stable(status[ST_C]) && $stable(status[ST_AC]) && $stable(status[ST_OV]));

endmodule

// File: tb/alu8_status_tb.sv
module alu8_status_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_a = '0;
   logic [7:0] op_b = '0;
   logic [3:0] opcode = '0;
   logic       flag_en = 1'b0;
   logic       st_wr = 1'b0;
   logic [7:0] st_wdata = '0;
   logic       ev_pwrup = 1'b0;
   logic       ev_halt = 1'b0;
   logic       ev_clrwdt = 1'b0;
   logic       ev_wdtovf = 1'b0;
   logic [7:0] result;
   logic       res_zero;
   logic [7:0] status;

   int n_checks = 0;
   int n_fail = 0;
   logic [7:0] m_st = 8'h00;

   always #2 clk = ~clk;

   alu8_status u_dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
      .flag_en(flag_en), .st_wr(st_wr), .st_wdata(st_wdata),
      .ev_pwrup(ev_pwrup), .ev_halt(ev_halt), .ev_clrwdt(ev_clrwdt),
      .ev_wdtovf(ev_wdtovf), .result(result), .res_zero(res_zero), .status(status)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // reference from the requirements: returns {new status, result}
   function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] st);
      logic [7:0] r, be, st_n;
      logic [8:0] s1, s2;
      logic [3:0] mask, nf;
      logic c, ac, ov, ci;
      int sum, lo, m7;
      c = st[0]; ac = st[1]; ov = st[3]; r = '0; mask = '0; be = b; ci = 1'b0;
      case (op)
         4'd0, 4'd1, 4'd2, 4'd3: begin
            be  = (op >= 4'd2) ? ~b : b;
            ci  = (op == 4'd0) ? 1'b0 : (op == 4'd2) ? 1'b1 : st[0];
            sum = int'(a) + int'(be) + int'(ci);
            lo  = int'(a[3:0]) + int'(be[3:0]) + int'(ci);
            m7  = int'(a[6:0]) + int'(be[6:0]) + int'(ci);
            r   = sum[7:0];
            c   = sum > 255;
            ac  = lo > 15;
            ov  = (m7 > 127) ^ c;
            mask = 4'b1111;
         end
         4'd4: begin
            s1 = {1'b0, a} + (((a[3:0] > 4'd9) || st[1]) ? 9'd6 : 9'd0);
            s2 = {1'b0, s1[7:0]} + (((s1[7:4] > 4'd9) || st[0]) ? 9'h60 : 9'd0);
            r  = s2[7:0];
            c  = st[0] | s1[8] | s2[8];
            mask = 4'b0101;
         end
         4'd5:  begin r = a & b;  mask = 4'b0100; end
         4'd6:  begin r = a | b;  mask = 4'b0100; end
         4'd7:  begin r = a ^ b;  mask = 4'b0100; end
         4'd8:  begin r = ~a;     mask = 4'b0100; end
         4'd13: begin r = a + 8'd1; mask = 4'b0100; end
         4'd14: begin r = a - 8'd1; mask = 4'b0100; end
         4'd9:  r = {a[6:0], a[7]};
         4'd10: r = {a[0], a[7:1]};
         4'd11: begin r = {a[6:0], st[0]}; c = a[7]; mask = 4'b0001; end
         4'd12: begin r = {st[0], a[7:1]}; c = a[0]; mask = 4'b0001; end
         default: r = '0;
      endcase
      nf = {ov, (r == 8'd0), ac, c};
      st_n = st;
      for (int i = 0; i < 4; i++) if (mask[i]) st_n[i] = nf[i];
      return {st_n, r};
   endfunction

   task automatic run_op(input string tag, input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic fe);
      logic [15:0] m;
      @(negedge clk);
      opcode = op; op_a = a; op_b = b; flag_en = fe;
      m = model(op, a, b, m_st);
      #1;
      check({tag, " result"}, result, m[7:0]);
      check({tag, " res_zero"}, {7'd0, res_zero}, {7'd0, (m[7:0] == 8'd0)});
      @(posedge clk);
      #1;
      flag_en = 1'b0;
      if (fe) m_st = m[15:8];
      check({tag, " status"}, status, m_st);
   endtask

   task automatic write_st(input string tag, input logic [7:0] d, input logic fe);
      @(negedge clk);
      st_wr = 1'b1; st_wdata = d; flag_en = fe;
      @(posedge clk);
      #1;
      st_wr = 1'b0; flag_en = 1'b0;
      m_st = {2'b00, m_st[5:4], d[3:0]};
      check(tag, status, m_st);
   endtask

   task automatic event_set(input string tag, input logic pw, input logic h,
                            input logic cw, input logic wo);
      logic pdf, to;
      @(negedge clk);
      ev_pwrup = pw; ev_halt = h; ev_clrwdt = cw; ev_wdtovf = wo;
      pdf = m_st[4]; to = m_st[5];
      if (pw) begin pdf = 1'b0; to = 1'b0; end
      else begin
         if (h) pdf = 1'b1; else if (cw) pdf = 1'b0;
         if (wo) to = 1'b1; else if (h || cw) to = 1'b0;
      end
      @(posedge clk);
      #1;
      ev_pwrup = 1'b0; ev_halt = 1'b0; ev_clrwdt = 1'b0; ev_wdtovf = 1'b0;
      m_st[4] = pdf; m_st[5] = to;
      check(tag, status, m_st);
   endtask

   task automatic t_reset;
      check("R12 reset status", status, 8'h00);
   endtask

   task automatic t_add;
      run_op("R1 add 3c+12", 4'd0, 8'h3C, 8'h12, 1'b1);
      run_op("R1 add ff+01", 4'd0, 8'hFF, 8'h01, 1'b1);
      run_op("R1 adc carry in", 4'd1, 8'h10, 8'h20, 1'b1);
      run_op("R1 add 0f+01 half", 4'd0, 8'h0F, 8'h01, 1'b1);
   endtask

   task automatic t_sub;
      run_op("R2 sub 05-03", 4'd2, 8'h05, 8'h03, 1'b1);
      run_op("R2 sub 03-05", 4'd2, 8'h03, 8'h05, 1'b1);
      run_op("R2 sbc borrow", 4'd3, 8'h40, 8'h10, 1'b1);
      run_op("R2 sbc no borrow", 4'd3, 8'h40, 8'h10, 1'b1);
      run_op("R2 sub equal", 4'd2, 8'h77, 8'h77, 1'b1);
   endtask

   task automatic t_ov;
      run_op("R3 ov 7f+01", 4'd0, 8'h7F, 8'h01, 1'b1);
      run_op("R3 ov 80-01", 4'd2, 8'h80, 8'h01, 1'b1);
      run_op("R3 ov 80+80", 4'd0, 8'h80, 8'h80, 1'b1);
   endtask

   task automatic t_daa;
      run_op("R5 bcd add 15+27", 4'd0, 8'h15, 8'h27, 1'b1);
      run_op("R5 daa 3c", 4'd4, 8'h3C, 8'h00, 1'b1);
      run_op("R5 bcd add 99+01", 4'd0, 8'h99, 8'h01, 1'b1);
      run_op("R5 daa 9a", 4'd4, 8'h9A, 8'h00, 1'b1);
      run_op("R5 bcd add 19+28", 4'd0, 8'h19, 8'h28, 1'b1);
      run_op("R5 daa 41 ac", 4'd4, 8'h41, 8'h00, 1'b1);
   endtask

   task automatic t_logic;
      write_st("R9 preset flags", 8'h0B, 1'b0);
      run_op("R6 and", 4'd5, 8'hF0, 8'h0F, 1'b1);
      run_op("R6 or", 4'd6, 8'hA0, 8'h05, 1'b1);
      run_op("R6 xor", 4'd7, 8'h5A, 8'h5A, 1'b1);
      run_op("R6 cpl", 4'd8, 8'h00, 8'h00, 1'b1);
      run_op("R6 inc wrap", 4'd13, 8'hFF, 8'h00, 1'b1);
      run_op("R6 dec", 4'd14, 8'h01, 8'h00, 1'b1);
   endtask

   task automatic t_rot;
      write_st("R9 preset c=1", 8'h01, 1'b0);
      run_op("R7 rl", 4'd9, 8'h81, 8'h00, 1'b1);
      run_op("R7 rr", 4'd10, 8'h01, 8'h00, 1'b1);
      run_op("R7 rlc", 4'd11, 8'h40, 8'h00, 1'b1);
      run_op("R7 rlc out", 4'd11, 8'h80, 8'h00, 1'b1);
      run_op("R7 rrc in", 4'd12, 8'h02, 8'h00, 1'b1);
      run_op("R7 rrc out", 4'd12, 8'h01, 8'h00, 1'b1);
      run_op("R7 rr zero result", 4'd10, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_hold_and_reserved;
      write_st("R9 preset 0a", 8'h0A, 1'b0);
      run_op("R8 add no enable", 4'd0, 8'hFF, 8'h01, 1'b0);
      run_op("R8 sub no enable", 4'd2, 8'h01, 8'h02, 1'b0);
      run_op("R13 reserved", 4'd15, 8'h12, 8'h34, 1'b1);
   endtask

   task automatic t_status_write;
      event_set("R10 halt", 1'b0, 1'b1, 1'b0, 1'b0);
      event_set("R11 wdt ovf", 1'b0, 1'b0, 1'b0, 1'b1);
      write_st("R9 write ff keeps sys", 8'hFF, 1'b0);
      @(negedge clk);
      opcode = 4'd0; op_a = 8'h01; op_b = 8'h01;
      write_st("R9 write beats flag update", 8'h50, 1'b1);
   endtask

   task automatic t_events;
      event_set("R10 clr wdt", 1'b0, 1'b0, 1'b1, 1'b0);
      event_set("R11 wdt alone", 1'b0, 1'b0, 1'b0, 1'b1);
      event_set("R11 halt clears to", 1'b0, 1'b1, 1'b0, 1'b0);
      event_set("R10 halt and clr", 1'b0, 1'b1, 1'b1, 1'b0);
      event_set("R11 halt and wdt", 1'b0, 1'b1, 1'b0, 1'b1);
      event_set("R10 pwrup with halt wdt", 1'b1, 1'b1, 1'b0, 1'b1);
      event_set("R11 wdt and clr", 1'b0, 1'b0, 1'b1, 1'b1);
      event_set("R11 pwrup only", 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #400000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_ov();
      t_daa();
      t_logic();
      t_rot();
      t_hold_and_reserved();
      t_status_write();
      t_events();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule